// File: doc/BRIEF.md
# Two-Tier Prioritized Interrupt Controller

This block gathers up to five groups of 32 asynchronous interrupt sources. Each source is synchronized and its rising edges are caught in a sticky status bit. Software sees the sticky bits and acknowledges them through a small register-mapped read/write bus. The controller drives two request lines toward the CPU.

The low-tier request covers ordinary sources, each gated by its own enable bit. A fixed set of sources is wired instead into a fifteen-level high tier. Those sources are gated per level by a priority mask rather than per bit. The controller reports the highest pending, unmasked level as a vector.

A control group (group 6) holds the global enable and the priority mask. It also reports the high vector and two summary flags.

Top module: `icu_two_tier`

## Requirements
- R1: Source input bit i is interrupt line i+32, so it lands in group (i+32)/32 at bit (i+32)%32. Groups 1..5 exist. Line 0 (group 0) is not valid, and its registers read as 0.
- R2: Each source passes through a two-flop synchronizer. A rising edge of the synchronized level sets its status bit on the third clock edge after the input goes high. The bit then stays set when the input falls.
- R3: Writing the clear register of a group clears each status bit whose wdata bit is 1 and leaves the other bits alone.
- R4: If a new edge and a clear of the same bit fall in the same cycle, the bit ends up set.
- R5: irq_low_o is 1 when the global enable is set and some group has a bit that is pending, per-bit enabled and not a high-tier source.
- R6: A high-tier source never drives irq_low_o, even when its per-bit enable is set.
- R7: The high-tier levels are fixed. Group 5 bits 24 and 25 are level 15, bit 30 is level 14, bit 29 is level 13, and bits 0 and 7 are level 1. Group 2 bit 31 is level 11, bit 21 is level 10 and bit 5 is level 5. Group 3 bits 16..19 are level 9. Group 4 bits 16..19 are level 7. Group 1 bit 18 is level 4, bit 17 is level 3 and bit 27 is level 2. Every other source is low tier.
- R8: The vector is the highest level n that has a pending source and mask bit n set. A vector of 0 means no such level. irq_high_o is the global enable ANDed with (vector != 0). An all-zero mask disables the high tier.
- R9: With the global enable at 0, both request outputs are 0, but status bits keep latching edges.
- R10: Synchronous active-low reset clears all status, synchronizer, enable, mask and global enable state.
- R11: The register map works as follows.
  - Address layout: bus_addr_i[4:3] selects the kind (0 = status, 1 = clear, 2 = enable), and bus_addr_i[2:0] selects the group.
  - Control group, status kind: read-only, with the high flag (vector != 0) in bit 31, the low flag (unqualified low pending) in bit 30 and the vector in bits 3:0.
  - Control group, enable kind: the global enable is bit 16 and the mask is bits 15:0.
  - Clear registers and unused addresses read 0. Writes to status registers are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | 160 | Asynchronous source levels, bit i is line i+32 |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 5 | {kind[1:0], group[2:0]} |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i (combinational) |
| irq_low_o | output | 1 | Low-tier request |
| irq_high_o | output | 1 | High-tier request |

## Verification
Two pairs of events can land in the same cycle.
- A source edge and a software clear of the same status bit. The bench times a clear write onto the exact clock edge where the synchronized edge arrives and expects the bit to survive.
- A global-enable change and an arriving edge. The random phase toggles sources while it writes clears, enables and control words. A behavioural model built from the requirements judges both request lines and the read data on every clock.

// File: rtl/icu_pkg.sv
// Shared constants, register kinds and the fixed high-tier level table.
package icu_pkg;

    localparam int GRP_W    = 32;
    localparam int NUM_GRP  = 5;
    localparam int LVL_N    = 16;
    localparam int VEC_W    = $clog2(LVL_N);
    localparam int CTRL_GRP = 6;
    localparam int GEN_BIT  = 16;
    localparam int HI_FLAG  = 31;
    localparam int LO_FLAG  = 30;

    typedef enum logic [1:0] {
        KIND_STAT = 2'd0,
        KIND_CLR  = 2'd1,
        KIND_EN   = 2'd2,
        KIND_NONE = 2'd3
    } reg_kind_e;

    // Priority level of source (grp, bit); 0 means the source is low tier.
    function automatic logic [3:0] src_level(input int grp, input int bt);
        logic [3:0] lv;
        lv = 4'd0;
        if (grp == 5) begin
            if (bt == 24 || bt == 25) lv = 4'd15;
            else if (bt == 30)        lv = 4'd14;
            else if (bt == 29)        lv = 4'd13;
            else if (bt == 0 || bt == 7) lv = 4'd1;
        end else if (grp == 2) begin
            if (bt == 31)      lv = 4'd11;
            else if (bt == 21) lv = 4'd10;
            else if (bt == 5)  lv = 4'd5;
        end else if (grp == 3) begin
            if (bt >= 16 && bt <= 19) lv = 4'd9;
        end else if (grp == 4) begin
            if (bt >= 16 && bt <= 19) lv = 4'd7;
        end else if (grp == 1) begin
            if (bt == 18)      lv = 4'd4;
            else if (bt == 17) lv = 4'd3;
            else if (bt == 27) lv = 4'd2;
        end
        return lv;
    endfunction

endpackage

// File: rtl/icu_src_group.sv
// One source group: two-flop synchronizer, rising-edge detect, sticky status.
// Assumes clr_i is already decoded to this group; an edge beats a clear.
module icu_src_group #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] src_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] status_o
);
    logic [W-1:0] sync1_q, sync2_q, prev_q, stat_q;
    logic [W-1:0] rise;

    assign rise = sync2_q & ~prev_q;

    // Synchronize sources and keep the previous synchronized level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1_q <= '0;
            sync2_q <= '0;
            prev_q  <= '0;
        end else begin
            sync1_q <= src_i;
            sync2_q <= sync1_q;
            prev_q  <= sync2_q;
        end
    end

    // Sticky status: cleared by write-one, set by a new edge (edge wins).
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~clr_i) | rise;
    end

    assign status_o = stat_q;

    AST_EDGE_SETS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (rise != '0) |=> ((stat_q & $past(rise)) == $past(rise))); // R2
    AST_CLEAR_DROPS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i != '0) |=> ((stat_q & $past(clr_i & ~rise)) == '0)); // R3
    AST_EDGE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_i & rise) != '0) |=> ((stat_q & $past(clr_i & rise)) == $past(clr_i & rise))); // R4
endmodule

// File: rtl/icu_prio_resolve.sv
// Maps status bits onto the fixed level table, applies the level mask and
// picks the highest pending level. Also reports which bits are high tier.
module icu_prio_resolve #(
    parameter int NG    = 5,
    parameter int W     = 32,
    parameter int LVLS  = 16,
    localparam int VW   = $clog2(LVLS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NG*W-1:0] status_i,
    input  logic [LVLS-1:0] mask_i,
    output logic [NG*W-1:0] hi_member_o,
    output logic [VW-1:0]   vec_o
);
    import icu_pkg::*;

    logic [LVLS-1:0] lvl_pend;
    logic [LVLS-1:0] lvl_hit;

    // Collect pending high-tier sources per level and mark membership.
    always_comb begin
        logic [3:0] lv;
        lvl_pend    = '0;
        hi_member_o = '0;
        for (int g = 0; g < NG; g++) begin
            for (int b = 0; b < W; b++) begin
                lv = src_level(g + 1, b);
                if (lv != 4'd0) begin
                    hi_member_o[g*W+b] = 1'b1;
                    if (status_i[g*W+b]) lvl_pend[lv] = 1'b1;
                end
            end
        end
    end

    assign lvl_hit = lvl_pend & mask_i;

    // Priority encode: the highest unmasked pending level wins; 0 = none.
    always_comb begin
        vec_o = '0;
        for (int l = 1; l < LVLS; l++) begin
            if (lvl_hit[l]) vec_o = VW'(l);
        end
    end

    AST_VEC_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_o != '0) |-> mask_i[vec_o]); // R8
endmodule

// File: rtl/icu_two_tier.sv
// Two-tier interrupt controller top: register bus, enables, control group,
// request generation. Assumes single-cycle writes and combinational reads.
module icu_two_tier #(
    parameter int NUM_GRP = 5,
    parameter int GRP_W   = 32,
    parameter int LVL_N   = 16,
    localparam int SRC_N  = NUM_GRP * GRP_W,
    localparam int VEC_W  = $clog2(LVL_N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_N-1:0] src_i,
    input  logic             bus_wr_i,
    input  logic [4:0]       bus_addr_i,
    input  logic [31:0]      bus_wdata_i,
    output logic [31:0]      bus_rdata_o,
    output logic             irq_low_o,
    output logic             irq_high_o
);
    import icu_pkg::*;

    logic [NUM_GRP-1:0][GRP_W-1:0] en_q;
    logic [NUM_GRP-1:0][GRP_W-1:0] clr_vec;
    logic [SRC_N-1:0]              status_all;
    logic [SRC_N-1:0]              hi_member;
    logic [LVL_N-1:0]              mask_q;
    logic                          gen_q;
    logic [VEC_W-1:0]              vec;
    logic                          low_pend;
    reg_kind_e                     kind;
    int                            grp;

    assign kind = reg_kind_e'(bus_addr_i[4:3]);
    assign grp  = int'(bus_addr_i[2:0]);

    for (genvar gi = 0; gi < NUM_GRP; gi++) begin : g_grp
        // Decode clear strobes for this group.
        assign clr_vec[gi] = (bus_wr_i && kind == KIND_CLR && grp == gi + 1)
                             ? bus_wdata_i[GRP_W-1:0] : '0;

        icu_src_group #(.W(GRP_W)) i_grp (
            .clk      (clk),
            .rst_n    (rst_n),
            .src_i    (src_i[gi*GRP_W +: GRP_W]),
            .clr_i    (clr_vec[gi]),
            .status_o (status_all[gi*GRP_W +: GRP_W])
        );
    end

    icu_prio_resolve #(.NG(NUM_GRP), .W(GRP_W), .LVLS(LVL_N)) i_prio (
        .clk         (clk),
        .rst_n       (rst_n),
        .status_i    (status_all),
        .mask_i      (mask_q),
        .hi_member_o (hi_member),
        .vec_o       (vec)
    );

    // Per-bit enables and the control group's enable word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            mask_q <= '0;
            gen_q  <= 1'b0;
        end else if (bus_wr_i && kind == KIND_EN) begin
            for (int g = 0; g < NUM_GRP; g++) begin
                if (grp == g + 1) en_q[g] <= bus_wdata_i[GRP_W-1:0];
            end
            if (grp == CTRL_GRP) begin
                gen_q  <= bus_wdata_i[GEN_BIT];
                mask_q <= bus_wdata_i[LVL_N-1:0];
            end
        end
    end

    // Low tier: enabled pending bits that are not high-tier sources.
    assign low_pend   = |(status_all & en_q & ~hi_member);
    assign irq_low_o  = gen_q & low_pend;
    assign irq_high_o = gen_q & (vec != '0);

    // Combinational read mux.
    always_comb begin
        bus_rdata_o = '0;
        for (int g = 0; g < NUM_GRP; g++) begin
            if (grp == g + 1) begin
                if (kind == KIND_STAT) bus_rdata_o = 32'(status_all[g*GRP_W +: GRP_W]);
                if (kind == KIND_EN)   bus_rdata_o = 32'(en_q[g]);
            end
        end
        if (grp == CTRL_GRP && kind == KIND_STAT) begin
            bus_rdata_o[HI_FLAG]     = (vec != '0);
            bus_rdata_o[LO_FLAG]     = low_pend;
            bus_rdata_o[VEC_W-1:0]   = vec;
        end
        if (grp == CTRL_GRP && kind == KIND_EN) begin
            bus_rdata_o[GEN_BIT]     = gen_q;
            bus_rdata_o[LVL_N-1:0]   = mask_q;
        end
    end

    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !gen_q |-> (!irq_low_o && !irq_high_o)); // R9
    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (gen_q == 1'b0 && mask_q == '0 && status_all == '0)); // R10
    AST_HIGH_NOT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_all & en_q & ~hi_member) == '0) |-> !irq_low_o); // R6
endmodule

// File: tb/test_icu_two_tier.sv
// Self-checking bench with a behavioural reference model compared every clock.
module test_icu_two_tier;
    localparam int CLK_P = 10;
    localparam int NG    = 5;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [159:0] src = '0;
    logic         wr = 1'b0;
    logic [4:0]   addr = '0;
    logic [31:0]  wdata = '0;
    logic [31:0]  rdata;
    logic         irq_low, irq_high;

    int total = 0;
    int bad   = 0;
    bit cmp_on = 1'b0;
    bit done   = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    icu_two_tier i_icu_two_tier (
        .clk(clk), .rst_n(rst_n), .src_i(src), .bus_wr_i(wr),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .irq_low_o(irq_low), .irq_high_o(irq_high)
    );

    // ---------------- reference model ----------------
    logic [31:0] m_s1[NG], m_s2[NG], m_pv[NG], m_st[NG], m_en[NG];
    logic [15:0] m_mask;
    logic        m_gen;

    function automatic int lvl(int g, int b);
        if (g == 1) return (b == 18) ? 4 : (b == 17) ? 3 : (b == 27) ? 2 : 0;
        if (g == 2) return (b == 31) ? 11 : (b == 21) ? 10 : (b == 5) ? 5 : 0;
        if (g == 3) return (b > 15 && b < 20) ? 9 : 0;
        if (g == 4) return (b > 15 && b < 20) ? 7 : 0;
        if (g == 5) begin
            if (b == 25 || b == 24) return 15;
            if (b == 30) return 14;
            if (b == 29) return 13;
            if (b == 7 || b == 0) return 1;
        end
        return 0;
    endfunction

    function automatic bit m_lowpend();
        for (int g = 0; g < NG; g++)
            for (int b = 0; b < 32; b++)
                if (m_st[g][b] && m_en[g][b] && lvl(g + 1, b) == 0) return 1'b1;
        return 1'b0;
    endfunction

    function automatic int m_vec();
        for (int l = 15; l >= 1; l--) begin
            if (m_mask[l]) begin
                for (int g = 0; g < NG; g++)
                    for (int b = 0; b < 32; b++)
                        if (m_st[g][b] && lvl(g + 1, b) == l) return l;
            end
        end
        return 0;
    endfunction

    function automatic logic [31:0] m_read(logic [4:0] a);
        int k, g;
        logic [31:0] r;
        k = int'(a[4:3]);
        g = int'(a[2:0]);
        r = '0;
        if (g >= 1 && g <= NG && k == 0) r = m_st[g-1];
        if (g >= 1 && g <= NG && k == 2) r = m_en[g-1];
        if (g == 6 && k == 0) r = {(m_vec() != 0), m_lowpend(), 26'd0, 4'(m_vec())};
        if (g == 6 && k == 2) r = {15'd0, m_gen, m_mask};
        return r;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int g = 0; g < NG; g++) begin
                m_s1[g] = '0; m_s2[g] = '0; m_pv[g] = '0; m_st[g] = '0; m_en[g] = '0;
            end
            m_mask = '0;
            m_gen  = 1'b0;
        end else begin
            for (int g = 0; g < NG; g++) begin
                logic [31:0] e, c;
                e = m_s2[g] & ~m_pv[g];
                c = (wr && addr[4:3] == 2'd1 && int'(addr[2:0]) == g + 1) ? wdata : '0;
                m_st[g] = (m_st[g] & ~c) | e;
                m_pv[g] = m_s2[g];
                m_s2[g] = m_s1[g];
                m_s1[g] = src[g*32 +: 32];
                if (wr && addr[4:3] == 2'd2 && int'(addr[2:0]) == g + 1) m_en[g] = wdata;
            end
            if (wr && addr[4:3] == 2'd2 && addr[2:0] == 3'd6) begin
                m_gen  = wdata[16];
                m_mask = wdata[15:0];
            end
        end
    end

    // ---------------- checking ----------------
    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Every-cycle comparison against the model, a quarter period after negedge.
    always @(negedge clk) begin
        #(CLK_P/4);
        if (cmp_on && !done) begin
            check("R5 irq_low", 32'(irq_low), 32'(m_gen & m_lowpend()));
            check("R8 irq_high", 32'(irq_high), 32'(m_gen & (m_vec() != 0)));
            check("R11 rdata", rdata, m_read(addr));
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bwrite(logic [4:0] a, logic [31:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bread(logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #(CLK_P/4);
        d = rdata;
    endtask

    localparam logic [4:0] CTRL_ST = {2'd0, 3'd6};
    localparam logic [4:0] CTRL_EN = {2'd2, 3'd6};

    function automatic logic [4:0] A(int kind, int g);
        return {2'(kind), 3'(g)};
    endfunction

    initial begin
        logic [31:0] d;
        cyc(4);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        cyc(1);
        // R10: reset state
        for (int g = 1; g <= NG; g++) begin
            bread(A(0, g), d); check("R10 status after reset", d, 0);
            bread(A(2, g), d); check("R10 enable after reset", d, 0);
        end
        bread(CTRL_EN, d); check("R10 control after reset", d, 0);
        check("R10 irq quiet", {30'd0, irq_low, irq_high}, 0);

        // R1/R2/R9: line 35 = group 1 bit 3; latches with global enable off
        bwrite(A(2, 1), 32'h8);
        src[3] = 1'b1;
        cyc(4);
        bread(A(0, 1), d); check("R1 R2 group1 bit3 latched", d, 32'h8);
        check("R9 low quiet with gen off", 32'(irq_low), 0);
        bread(A(0, 0), d); check("R1 group0 reads zero", d, 0);
        bwrite(CTRL_EN, 32'h1_0000);
        bread(CTRL_ST, d); check("R5 low flag", d, 32'h4000_0000);
        check("R5 irq_low asserted", 32'(irq_low), 1);
        src[3] = 1'b0;
        cyc(4);
        bread(A(0, 1), d); check("R2 sticky after source falls", d, 32'h8);

        // R3: clear write-one
        bwrite(A(1, 1), 32'h8);
        bread(A(0, 1), d); check("R3 cleared", d, 0);
        check("R3 low dropped", 32'(irq_low), 0);

        // R6/R7/R8: group5 bit30 (level 14), per-bit enabled
        bwrite(A(2, 5), 32'h4000_0000);
        src[4*32+30] = 1'b1;
        cyc(4);
        check("R6 high-tier source not low", 32'(irq_low), 0);
        check("R8 mask zero blocks high", 32'(irq_high), 0);
        bwrite(CTRL_EN, 32'h1_4000);
        bread(CTRL_ST, d); check("R7 vector 14", d, 32'h8000_000E);
        src[4*32+25] = 1'b1;
        cyc(4);
        bread(CTRL_ST, d); check("R8 masked level 15 ignored", d[3:0], 14);
        bwrite(CTRL_EN, 32'h1_C000);
        bread(CTRL_ST, d); check("R8 level 15 wins", d[3:0], 15);
        src[2*32+17] = 1'b1; src[3*32+16] = 1'b1; src[1*32+21] = 1'b1;
        cyc(4);
        bwrite(CTRL_EN, 32'h1_0280);
        bread(CTRL_ST, d); check("R7 group3 level 9", d[3:0], 9);
        bwrite(CTRL_EN, 32'h1_0080);
        bread(CTRL_ST, d); check("R7 group4 level 7", d[3:0], 7);
        bwrite(CTRL_EN, 32'h1_0400);
        bread(CTRL_ST, d); check("R7 group2 bit21 level 10", d[3:0], 10);
        check("R8 irq_high set", 32'(irq_high), 1);

        // R4: edge and clear in the same cycle
        src[3] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        wr = 1'b1; addr = A(1, 1); wdata = 32'h8;
        @(negedge clk);
        wr = 1'b0;
        bread(A(0, 1), d); check("R4 edge beats clear", d & 32'h8, 32'h8);

        // R9: global enable off forces requests low, status still latches
        bwrite(CTRL_EN, 32'h0_0400);
        src[4] = 1'b1;
        cyc(4);
        bread(A(0, 1), d); check("R9 latch with gen off", d & 32'h10, 32'h10);
        check("R9 both quiet", {30'd0, irq_low, irq_high}, 0);

        // R11: status write ignored
        bwrite(A(0, 1), 32'h0);
        bread(A(0, 1), d); check("R11 status write ignored", d & 32'h18, 32'h18);

        // Random phase: model comparison every clock
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if ($urandom_range(0, 3) == 0) src[$urandom_range(0, 159)] ^= 1'b1;
            if ($urandom_range(0, 5) == 0) begin
                wr = 1'b1;
                addr = 5'($urandom_range(0, 31));
                wdata = $urandom();
                if ($urandom_range(0, 1) == 1) addr = {2'd2, 3'd6};
            end else begin
                wr = 1'b0;
                addr = 5'($urandom_range(0, 31));
            end
        end
        wr = 1'b0;
        cyc(2);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog
    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule